// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block produces one pulse-width modulated output from a prescaled system clock. Software programs a period, a prescale divisor and an output polarity. It then feeds duty values into a small queue, and the generator consumes them one per output period. Because of the queue, a new compare value can be posted while the waveform keeps running, without waiting for a period boundary. When the queue runs dry, the generator keeps repeating the last duty value it took. A push into a full queue is lost, and a sticky flag records the loss.

Registers are reached through a plain synchronous strobe port that has four word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | sample push |
| 3 | period |

A write takes effect at the clock edge where `wr_en` is high. A read returns its data on `rdata` after the clock edge where `rd_en` is high, and `rdata` holds that value until the next read. A self-clearing soft reset, requested through the control register, returns the whole block to its power-on state.

Top module: `qpwm_top`

## Requirements
- R1: After `rst_n` is released, the control, status and period registers read 0 and `pwm_out` is 0.
- R2: The control register stores the following bits; every other bit reads 0, and bit 3 reads as the soft-reset busy flag.
  - Bit 0: enable.
  - Bits 15:4: prescale field.
  - Bits 17:16: clock-source select.
  - Bit 18: output inversion.
  - Bits 22, 23 and 24: three stored low-power flags.
  
  Writing 0xFFFFFFF7 therefore reads back 0x01C7FFF1.
- R3: While the enable bit is 1, an output period lasts (period + 2) × (prescale + 1) clock cycles. The first period begins on the clock edge that follows the write that sets enable.
- R4: Within each period, the non-inverted output is 1 for min(sample, period + 2) × (prescale + 1) cycles, starting at the beginning of the period, and 0 for the rest of the period.
- R5: Control bit 18 inverts `pwm_out` while the generator is enabled. When the generator is disabled, `pwm_out` is 0.
- R6: Each period start takes the oldest queued sample, in push order. A sample is also taken at the enabling edge. When the queue is empty, the previous sample is reused.
- R7: A write to address 2 pushes bits 15:0 of `wdata` into the 4-entry queue. Status bits 2:0 give the number of queued entries.
- R8: A push while the queue holds 4 entries is dropped, and status bit 8 becomes 1. Bit 8 stays 1 until a soft reset clears it.
- R9: Writing control with bit 3 set starts a soft reset.
  - The reset clears the queue, the overflow flag, the control and period registers and the counters.
  - Bit 3 reads 1 for `SWR_CYCLES` cycles and then clears by itself.
  - All register writes are ignored while the reset is in progress.
- R10: Writing 0 to the control register stops the generator, and `pwm_out` is 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered on a read strobe |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle, the embedded assertions check the following:
- The queue occupancy never exceeds its depth.
- A push into a full queue is refused and raises the sticky flag.
- The queue is empty throughout a soft reset.
- The prescaler never fires on two consecutive cycles when it divides by more than one.
- The period counter moves only on a prescaler tick.
- A start always begins at count zero.

The exact waveform shape can only be shown by the bench's scenarios. This covers the period length, the high time for every sample value around and beyond the period, inversion, the order in which queued samples are consumed, and reuse of the last sample. The bench sweeps prescale, period, sample and polarity over a small grid and counts the output's high cycles over whole periods.

// File: rtl/qpwm_pkg.sv
// Package: shared register addresses and control-field positions for the
// queued-duty PWM. Assumes a 32-bit register data path.
package qpwm_pkg;
    localparam int REG_W = 32;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_SAMPLE = 2'd2;
    localparam logic [1:0] A_PERIOD = 2'd3;

    localparam int B_EN      = 0;
    localparam int B_SWR     = 3;
    localparam int B_PRE_LSB = 4;
    localparam int B_SRC_LSB = 16;
    localparam int B_INV     = 18;
    localparam int B_LP_DBG  = 22;
    localparam int B_LP_WAIT = 23;
    localparam int B_LP_DOZE = 24;
    localparam int B_OVF     = 8;

    typedef struct packed {
        logic        lp_doze;
        logic        lp_wait;
        logic        lp_dbg;
        logic        inv;
        logic [1:0]  src;
        logic [11:0] pre;
        logic        en;
    } ctrl_t;
endpackage

// File: rtl/qpwm_prescaler.sv
// Module: clock prescaler. Emits a one-cycle tick every (div + 1) cycles.
// Assumes clr holds the phase at zero while the generator is not running.
module qpwm_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase;

    assign tick = !clr && (phase >= div);

    // Purpose: advance the divider phase, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R3: with a divisor above one, ticks are never back to back
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/qpwm_sample_fifo.sv
// Module: duty-sample queue. Refuses pushes when full and records a sticky
// overflow flag. Assumes the consumer pops only when the queue is non-empty.
module qpwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Purpose: store an accepted sample at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wptr] <= push_data;
        end
    end

    // Purpose: maintain the pointers, the occupancy and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
            if (push && full) begin
                overflow <= 1'b1;
            end
        end
    end

    // R7: occupancy never exceeds the depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R8: a push into a full queue without a pop is refused and flagged
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH) && overflow));
endmodule

// File: rtl/qpwm_period_core.sv
// Module: period counter, sample register and output compare. Loads a
// sample at enable and at each period wrap; reuses it when the queue is empty.
// Assumes tick comes from a prescaler cleared while not running.
module qpwm_period_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             enable,
    input  logic             invert,
    input  logic [CNT_W-1:0] period,
    input  logic             tick,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_head,
    output logic             pop,
    output logic             running,
    output logic [CNT_W-1:0] cur_sample,
    output logic             pwm_out
);
    logic [CNT_W:0] cnt;
    logic [CNT_W:0] last_cnt;
    logic           start, wrap, load;

    assign last_cnt = {1'b0, period} + 1'b1;
    assign start    = enable && !running && !clr;
    assign wrap     = (cnt >= last_cnt);
    assign load     = start || (running && enable && tick && wrap && !clr);
    assign pop      = load && !fifo_empty;
    assign pwm_out  = running && ((cnt < {1'b0, cur_sample}) ^ invert);

    // Purpose: track whether a period sequence is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            running <= 1'b0;
        end else begin
            running <= enable;
        end
    end

    // Purpose: count prescaled ticks within a period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !enable || start) begin
            cnt <= '0;
        end else if (running && tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // Purpose: take the next duty sample at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur_sample <= '0;
        end else if (pop) begin
            cur_sample <= fifo_head;
        end
    end

    // R3: the counter moves only on a prescaler tick
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && !tick && !clr) |=> $stable(cnt));
    // R3: a new sequence always begins at count zero
    assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && cnt == '0));
    // R5: the output is quiet whenever the generator is not running
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || clr) |=> !pwm_out);
endmodule

// File: rtl/qpwm_top.sv
// Module: queued-duty PWM top. Holds the register file, the soft-reset
// sequencer and the read mux, and wires the prescaler, queue and core.
// Assumes one synchronous strobe port; reads return one cycle after rd_en.
module qpwm_top #(
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int SWR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        pwm_out
);
    import qpwm_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam int SW = $clog2(SWR_CYCLES+1);

    logic             en_q, inv_q, dbg_q, wait_q, doze_q;
    logic [PRE_W-1:0] pre_q;
    logic [1:0]       src_q;
    logic [CNT_W-1:0] period_q;
    logic [SW-1:0]    swr_cnt;
    logic             busy, wr_ok, swr_req, push;
    logic             tick, pop, running, fifo_empty, overflow;
    logic [CNT_W-1:0] fifo_head, cur_sample;
    logic [CW-1:0]    fifo_count;
    logic [31:0]      rd_mux;

    assign busy    = (swr_cnt != '0);
    assign wr_ok   = wr_en && !busy;
    assign swr_req = wr_ok && (addr == A_CTRL) && wdata[B_SWR];
    assign push    = wr_ok && (addr == A_SAMPLE);

    // Purpose: count down the soft-reset window after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swr_cnt <= '0;
        end else if (swr_req) begin
            swr_cnt <= SW'(SWR_CYCLES);
        end else if (busy) begin
            swr_cnt <= swr_cnt - 1'b1;
        end
    end

    // Purpose: hold the control fields; a soft reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_req) begin
            en_q   <= 1'b0;
            pre_q  <= '0;
            src_q  <= '0;
            inv_q  <= 1'b0;
            dbg_q  <= 1'b0;
            wait_q <= 1'b0;
            doze_q <= 1'b0;
        end else if (wr_ok && addr == A_CTRL) begin
            en_q   <= wdata[B_EN];
            pre_q  <= wdata[B_PRE_LSB +: PRE_W];
            src_q  <= wdata[B_SRC_LSB +: 2];
            inv_q  <= wdata[B_INV];
            dbg_q  <= wdata[B_LP_DBG];
            wait_q <= wdata[B_LP_WAIT];
            doze_q <= wdata[B_LP_DOZE];
        end
    end

    // Purpose: hold the period register; a soft reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_req) begin
            period_q <= '0;
        end else if (wr_ok && addr == A_PERIOD) begin
            period_q <= wdata[CNT_W-1:0];
        end
    end

    // Purpose: select the word for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_CTRL: begin
                rd_mux[B_EN]                 = en_q;
                rd_mux[B_SWR]                = busy;
                rd_mux[B_PRE_LSB +: PRE_W]   = pre_q;
                rd_mux[B_SRC_LSB +: 2]       = src_q;
                rd_mux[B_INV]                = inv_q;
                rd_mux[B_LP_DBG]             = dbg_q;
                rd_mux[B_LP_WAIT]            = wait_q;
                rd_mux[B_LP_DOZE]            = doze_q;
            end
            A_STATUS: begin
                rd_mux[CW-1:0]  = fifo_count;
                rd_mux[B_OVF]   = overflow;
            end
            A_SAMPLE: rd_mux[CNT_W-1:0] = cur_sample;
            default:  rd_mux[CNT_W-1:0] = period_q;
        endcase
    end

    // Purpose: register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    qpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!running),
        .div   (pre_q),
        .tick  (tick)
    );

    qpwm_sample_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy),
        .push      (push),
        .push_data (wdata[CNT_W-1:0]),
        .pop       (pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .count     (fifo_count),
        .overflow  (overflow)
    );

    qpwm_period_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (busy),
        .enable     (en_q),
        .invert     (inv_q),
        .period     (period_q),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .pop        (pop),
        .running    (running),
        .cur_sample (cur_sample),
        .pwm_out    (pwm_out)
    );

    // R9: the queue is empty while a soft reset is in progress
    assert_swr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fifo_count == '0 && !overflow));
    // R9: a soft-reset request raises the busy flag on the next cycle
    assert_swr_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swr_req |=> busy);
endmodule

// File: tb/qpwm_top_bench.sv
module qpwm_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SWR_CYC    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    qpwm_top #(.SWR_CYCLES(SWR_CYC)) u_qpwm_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic soft_reset();
        wr(2'd0, 32'h8);
        repeat (SWR_CYC + 2) @(negedge clk);
    endtask

    // Count high cycles of pwm_out over n cycles starting at the next start edge.
    task automatic measure(input int n, output int highs, output logic [63:0] trace);
        highs = 0;
        trace = '0;
        for (int i = 0; i < n; i++) begin
            if (i < 64) trace[i] = pwm_out;
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int          highs;
        logic [63:0] tr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); check("R1 control after reset", v, 32'h0);
        rd(2'd1, v); check("R1 status after reset", v, 32'h0);
        rd(2'd3, v); check("R1 period after reset", v, 32'h0);
        check("R1 pwm_out after reset", {31'd0, pwm_out}, 32'h0);

        // R2: control readback mask
        wr(2'd0, 32'hFFFF_FFF7);
        rd(2'd0, v); check("R2 control readback", v, 32'h01C7_FFF1);
        // R10: writing zero stops the output
        wr(2'd0, 32'h0);
        @(negedge clk);
        check("R10 output after disable", {31'd0, pwm_out}, 32'h0);
        rd(2'd0, v); check("R10 control cleared", v, 32'h0);

        // R3 R4 R5: sweep prescale, period, sample and polarity
        for (int pre = 0; pre < 3; pre++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int per, tot, smax;
                per  = (pi == 2) ? 3 : pi;
                tot  = (per + 2) * (pre + 1);
                smax = per + 3;
                for (int s = 0; s <= smax; s++) begin
                    for (int inv = 0; inv < 2; inv++) begin
                        int hi_exp;
                        soft_reset();
                        wr(2'd3, 32'(per));
                        wr(2'd2, 32'(s));
                        wr(2'd0, 32'(1 | (pre << 4) | (inv << 18)));
                        @(posedge clk);
                        @(negedge clk);
                        measure(2 * tot, highs, tr);
                        hi_exp = ((s < per + 2) ? s : per + 2) * (pre + 1);
                        if (inv == 1) hi_exp = tot - hi_exp;
                        if (inv == 0) check("R4 high cycles over two periods", 32'(highs), 32'(2 * hi_exp));
                        else          check("R5 inverted high cycles", 32'(highs), 32'(2 * hi_exp));
                        if (s == 1 && inv == 0) begin
                            check("R3 low before next period", {31'd0, tr[tot-1]}, 32'h0);
                            check("R3 high at next period start", {31'd0, tr[tot]}, 32'h1);
                        end
                    end
                end
            end
        end

        // R6 R7: queue ordering and reuse of the last sample
        soft_reset();
        wr(2'd3, 32'd6);
        wr(2'd2, 32'd1);
        wr(2'd2, 32'd5);
        wr(2'd2, 32'd3);
        rd(2'd1, v); check("R7 count after three pushes", v, 32'd3);
        wr(2'd0, 32'h1);
        @(posedge clk);
        @(negedge clk);
        measure(8, highs, tr); check("R6 first sample", 32'(highs), 32'd1);
        measure(8, highs, tr); check("R6 second sample", 32'(highs), 32'd5);
        measure(8, highs, tr); check("R6 third sample", 32'(highs), 32'd3);
        measure(8, highs, tr); check("R6 reuse when empty", 32'(highs), 32'd3);
        rd(2'd1, v); check("R7 queue drained", v, 32'd0);

        // R8: overflow
        soft_reset();
        for (int k = 0; k < 5; k++) wr(2'd2, 32'(k + 1));
        rd(2'd1, v); check("R8 full with sticky overflow", v, 32'h104);
        wr(2'd3, 32'd2);
        rd(2'd1, v); check("R8 overflow stays set", v, 32'h104);

        // R9: soft reset behaviour
        wr(2'd0, 32'h8);
        rd(2'd0, v); check("R9 busy flag during reset", v, 32'h8);
        wr(2'd3, 32'd5);
        repeat (SWR_CYC + 2) @(negedge clk);
        rd(2'd0, v); check("R9 busy flag self-clears", v, 32'h0);
        rd(2'd1, v); check("R9 queue and flag cleared", v, 32'h0);
        rd(2'd3, v); check("R9 write ignored during reset", v, 32'h0);

        finish_run();
    end
endmodule